// File: doc/BRIEF.md
# Register-Mapped I2C Master Controller

This block gives a host processor a small register window for running an I2C master at the byte level. The host writes the control register to enable the block, pick master or receive mode and allow interrupts. It then moves bytes through a single data register. The first data byte after a start carries the target address and the direction bit. Later writes send data. Each read hands back the byte received before and fetches the next one.

The bit-level serial engine is a separate block. This controller passes one operation at a time to it over a transaction port: start, send, receive or end. It waits for a completion pulse that carries an ack or nack, then updates the status flags and may raise its interrupt line. Status flags clear only when the host writes a zero over a set bit. Turning the enable bit off performs a soft reset. The soft reset keeps the own-address register and closes any open transfer.

Top module: `i2c_host_ctrl`

## Requirements
- R1: The interrupt flag (status bit 1) is set only when both the enable bit (control bit 7) and the interrupt-enable bit (control bit 6) are 1. The `irq` output follows that flag.
- R2: A control write that clears bit 7 while the block is enabled is a soft reset. Control, divider, status and the read holding byte return to 0, the own-address register keeps its value, and an open transfer is closed with an end operation.
- R3: A normal control write copies the master bit (control bit 5) into bus-busy (status bit 5). Clearing the master bit while a transfer is open issues an end operation and forgets the address.
- R4: A control write with repeat-start (control bit 2) set while a transfer is open issues an end operation, forgets the address and clears bit 2. With no transfer open, bit 2 is stored as written.
- R5: Data writes are ignored while the block is disabled. In master mode, a data write with no open transfer issues a start whose address is byte bits 7:1 and whose direction is bit 0.
- R6: A nacked start sets received-ack (status bit 0) and raises no interrupt. An acked start opens the transfer, clears status bit 0 and raises the interrupt.
- R7: A data write during an open transfer issues a send. On nack it sets status bit 0, closes the transfer and issues an end. On ack it clears status bit 0 and raises the interrupt.
- R8: A data read in master mode returns the held byte. With a transfer open and transmit mode (control bit 4) clear, it issues a receive whose byte becomes the new held byte and raises the interrupt. Otherwise the held byte becomes 0xFF and nothing is issued.
- R9: Status bits 1 and 4 clear only when a 0 is written over them. Writing 1 leaves them unchanged.
- R10: Offsets are 0 own address (mask 0xFE), 1 divider (mask 0x3F), 2 control (mask 0xFC), 3 status and 4 data. Offsets 5 to 7 read 0 and ignore writes.
- R11: The transaction port codes are 0 start, 1 send, 2 receive and 3 end. `op_valid` and the operation fields stay steady until `op_done`, and only the expected operations appear.
- R12: While an operation is pending, `reg_ready` is low for the data and control offsets and high for the others.
- R13: If a completion raises the interrupt flag in the same cycle as a status write that clears it, the flag ends up set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Host write strobe, held until accepted |
| reg_rd | input | 1 | Host read strobe, held until accepted |
| reg_off | input | 3 | Register offset |
| reg_wdata | input | 8 | Host write data |
| reg_rdata | output | 8 | Read data for the current offset |
| reg_ready | output | 1 | Host access accepted on this edge |
| op_valid | output | 1 | Operation pending on transaction port |
| op_code | output | 2 | Operation code |
| op_addr | output | 7 | Target address for start |
| op_dir | output | 1 | Direction for start, 1 is read |
| op_wbyte | output | 8 | Byte for send |
| op_done | input | 1 | Completion pulse |
| op_nack | input | 1 | Completion carried a nack |
| op_rbyte | input | 8 | Received byte, valid with completion |
| irq | output | 1 | Interrupt line |

## Verification
Status writes are never stalled. A host write that clears the interrupt flag can therefore land on the same edge as a completion pulse that sets it. The bench holds the bus model's completion back under manual control. It times the status write and the completion pulse so that both reach the same rising edge. It then reads status and `irq` and expects the flag to be set. A separate plain clear afterwards confirms that the write path itself works.

// File: rtl/i2c_host_ctrl.sv
module i2c_host_ctrl #(
  parameter int         OFF_W     = 3,
  parameter logic [7:0] OWN_MASK  = 8'hFE,
  parameter logic [7:0] DIV_MASK  = 8'h3F,
  parameter logic [7:0] CTRL_MASK = 8'hFC
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             reg_wr,
  input  logic             reg_rd,
  input  logic [OFF_W-1:0] reg_off,
  input  logic [7:0]       reg_wdata,
  output logic [7:0]       reg_rdata,
  output logic             reg_ready,
  output logic             op_valid,
  output logic [1:0]       op_code,
  output logic [6:0]       op_addr,
  output logic             op_dir,
  output logic [7:0]       op_wbyte,
  input  logic             op_done,
  input  logic             op_nack,
  input  logic [7:0]       op_rbyte,
  output logic             irq
);

  localparam logic [OFF_W-1:0] A_OWN  = OFF_W'(0);
  localparam logic [OFF_W-1:0] A_DIV  = OFF_W'(1);
  localparam logic [OFF_W-1:0] A_CTRL = OFF_W'(2);
  localparam logic [OFF_W-1:0] A_STAT = OFF_W'(3);
  localparam logic [OFF_W-1:0] A_DATA = OFF_W'(4);

  localparam int C_EN = 7, C_IEN = 6, C_MST = 5, C_TX = 4, C_RSTA = 2;
  localparam int S_BB = 5, S_AL = 4, S_IF = 1, S_RXAK = 0;
  localparam logic [7:0] RSTA_BIT = 8'(1 << C_RSTA);

  localparam logic [1:0] OP_START = 2'd0, OP_SEND = 2'd1, OP_RECV = 2'd2, OP_END = 2'd3;

  logic [7:0] own_q, div_q, ctrl_q, stat_q, rd_hold, byte_q;
  logic       act_q, busy_q;
  logic [1:0] code_q;

  wire        stall      = busy_q && (reg_off == A_DATA || reg_off == A_CTRL);
  wire        wr_ok      = reg_wr && !stall;
  wire        rd_ok      = reg_rd && !reg_wr && !stall;
  wire [7:0]  ctrl_new   = reg_wdata & CTRL_MASK;
  wire        soft_rst   = ctrl_q[C_EN] && !reg_wdata[C_EN];
  wire        end_on_ctl = act_q && (!ctrl_new[C_MST] || ctrl_new[C_RSTA]);
  wire        irq_en     = ctrl_q[C_EN] && ctrl_q[C_IEN];

  assign reg_ready = !stall;
  assign op_valid  = busy_q;
  assign op_code   = code_q;
  assign op_addr   = byte_q[7:1];
  assign op_dir    = byte_q[0];
  assign op_wbyte  = byte_q;
  assign irq       = stat_q[S_IF];

  always_comb begin
    case (reg_off)
      A_OWN:   reg_rdata = own_q;
      A_DIV:   reg_rdata = div_q;
      A_CTRL:  reg_rdata = ctrl_q;
      A_STAT:  reg_rdata = stat_q;
      A_DATA:  reg_rdata = rd_hold;
      default: reg_rdata = 8'h00;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      own_q   <= '0;
      div_q   <= '0;
      ctrl_q  <= '0;
      stat_q  <= '0;
      rd_hold <= '0;
      byte_q  <= '0;
      act_q   <= 1'b0;
      busy_q  <= 1'b0;
      code_q  <= OP_START;
    end else begin
      if (wr_ok) begin
        case (reg_off)
          A_OWN: own_q <= reg_wdata & OWN_MASK;
          A_DIV: div_q <= reg_wdata & DIV_MASK;
          A_CTRL: begin
            if (soft_rst) begin
              ctrl_q  <= '0;
              div_q   <= '0;
              stat_q  <= '0;
              rd_hold <= '0;
              byte_q  <= '0;
              act_q   <= 1'b0;
              if (act_q) begin
                busy_q <= 1'b1;
                code_q <= OP_END;
              end
            end else begin
              ctrl_q       <= (act_q && ctrl_new[C_RSTA]) ? (ctrl_new & ~RSTA_BIT) : ctrl_new;
              stat_q[S_BB] <= ctrl_new[C_MST];
              if (end_on_ctl) begin
                act_q  <= 1'b0;
                busy_q <= 1'b1;
                code_q <= OP_END;
              end
            end
          end
          A_STAT: begin
            stat_q[S_IF] <= stat_q[S_IF] & reg_wdata[S_IF];
            stat_q[S_AL] <= stat_q[S_AL] & reg_wdata[S_AL];
          end
          A_DATA: begin
            if (ctrl_q[C_EN]) begin
              byte_q <= reg_wdata;
              if (ctrl_q[C_MST]) begin
                busy_q <= 1'b1;
                code_q <= act_q ? OP_SEND : OP_START;
              end
            end
          end
          default: ;
        endcase
      end else if (rd_ok && reg_off == A_DATA && ctrl_q[C_MST]) begin
        if (act_q && !ctrl_q[C_TX]) begin
          busy_q <= 1'b1;
          code_q <= OP_RECV;
        end else begin
          rd_hold <= 8'hFF;
        end
      end

      if (busy_q && op_done) begin
        busy_q <= 1'b0;
        case (code_q)
          OP_START: begin
            stat_q[S_RXAK] <= op_nack;
            if (!op_nack) begin
              act_q <= 1'b1;
              if (irq_en) stat_q[S_IF] <= 1'b1;
            end
          end
          OP_SEND: begin
            stat_q[S_RXAK] <= op_nack;
            if (op_nack) begin
              act_q  <= 1'b0;
              busy_q <= 1'b1;
              code_q <= OP_END;
            end else if (irq_en) begin
              stat_q[S_IF] <= 1'b1;
            end
          end
          OP_RECV: begin
            rd_hold <= op_rbyte;
            if (irq_en) stat_q[S_IF] <= 1'b1;
          end
          default: ;
        endcase
      end
    end
  end

endmodule

// File: rtl/i2c_host_ctrl_chk.sv
module i2c_host_ctrl_chk #(
  parameter int OFF_W = 3
) (
  input logic             clk,
  input logic             rst_n,
  input logic             reg_wr,
  input logic             reg_ready,
  input logic [OFF_W-1:0] reg_off,
  input logic [7:0]       reg_wdata,
  input logic [7:0]       ctrl_q,
  input logic [7:0]       stat_q,
  input logic             irq,
  input logic             op_valid,
  input logic [1:0]       op_code,
  input logic             op_done,
  input logic             op_nack
);

  wire ctl_wr  = reg_wr && reg_ready && reg_off == OFF_W'(2);
  wire stat_wr = reg_wr && reg_ready && reg_off == OFF_W'(3);

  AST_IRQ_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> $past(ctrl_q[7] && ctrl_q[6])); // R1

  AST_SOFT_RESET: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_wr && ctrl_q[7] && !reg_wdata[7]) |=> (ctrl_q == 8'h00 && stat_q == 8'h00)); // R2

  AST_BUSY_FOLLOWS_MASTER: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_wr && !(ctrl_q[7] && !reg_wdata[7])) |=> stat_q[5] == $past(reg_wdata[5])); // R3

  AST_START_NACK_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && op_done && op_nack && op_code == 2'd0) |=> (stat_q[0] && !$rose(irq))); // R6

  AST_SEND_NACK_ENDS: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && op_done && op_nack && op_code == 2'd1) |=> (op_valid && op_code == 2'd3)); // R7

  AST_FLAG_WRITE_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_wr && reg_wdata[1] && stat_q[1]) |=> stat_q[1]); // R9

  AST_OP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && !op_done) |=> (op_valid && $stable(op_code))); // R11

endmodule

bind i2c_host_ctrl i2c_host_ctrl_chk #(.OFF_W(OFF_W)) i_chk (
  .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_ready(reg_ready),
  .reg_off(reg_off), .reg_wdata(reg_wdata), .ctrl_q(ctrl_q), .stat_q(stat_q),
  .irq(irq), .op_valid(op_valid), .op_code(op_code), .op_done(op_done),
  .op_nack(op_nack)
);

// File: tb/test_i2c_host_ctrl.sv
module test_i2c_host_ctrl;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0, rst_n = 1'b0;
  logic       reg_wr = 1'b0, reg_rd = 1'b0;
  logic [2:0] reg_off = '0;
  logic [7:0] reg_wdata = '0;
  logic [7:0] reg_rdata;
  logic       reg_ready, op_valid, op_dir, irq;
  logic [1:0] op_code;
  logic [6:0] op_addr;
  logic [7:0] op_wbyte;
  logic       op_done, op_nack;
  logic [7:0] op_rbyte;

  i2c_host_ctrl i_i2c_host_ctrl (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_off(reg_off),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .reg_ready(reg_ready),
    .op_valid(op_valid), .op_code(op_code), .op_addr(op_addr), .op_dir(op_dir),
    .op_wbyte(op_wbyte), .op_done(op_done), .op_nack(op_nack), .op_rbyte(op_rbyte),
    .irq(irq)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int n_chk = 0, n_bad = 0;
  bit finished = 0;

  task automatic check(input string req, input logic [15:0] got, input logic [15:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got=%0h exp=%0h", req, got, exp);
    end
  endtask

  // scoreboard of expected transaction-port operations: {nack, code, byte}
  logic [10:0] exp_q[$];
  logic        pend = 0, auto_done = 1, man_fire = 0, cur_nack = 0;
  logic [1:0]  cur_code = 0;
  logic [7:0]  rb = 8'h5A;
  int          op_seen = 0;

  task automatic expect_op(input logic [1:0] c, input logic [7:0] b, input logic nk);
    exp_q.push_back({nk, c, b});
  endtask

  initial begin
    op_done = 0; op_nack = 0; op_rbyte = 0;
    forever begin
      @(negedge clk);
      op_done = 0;
      if (pend) begin
        if (auto_done || man_fire) begin
          op_done = 1;
          op_nack = cur_nack;
          if (cur_code == 2'd2) begin
            op_rbyte = rb;
            rb = rb + 8'd1;
          end
          pend = 0;
          man_fire = 0;
        end
      end else if (op_valid && rst_n) begin
        op_seen++;
        if (exp_q.size() == 0) begin
          n_chk++; n_bad++;
          $display("FAIL R11 unexpected op: got=%0d exp=none", op_code);
          cur_nack = 0;
        end else begin
          logic [10:0] it;
          it = exp_q.pop_front();
          check("R11 op code", {14'b0, op_code}, {14'b0, it[9:8]});
          if (it[9:8] == 2'd0) check("R5 start addr/dir", {8'b0, op_addr, op_dir}, {8'b0, it[7:0]});
          if (it[9:8] == 2'd1) check("R7 send byte", {8'b0, op_wbyte}, {8'b0, it[7:0]});
          cur_nack = it[10];
        end
        cur_code = op_code;
        pend = 1;
      end
    end
  end

  task automatic wr(input logic [2:0] o, input logic [7:0] d);
    @(negedge clk);
    reg_wr = 1; reg_off = o; reg_wdata = d;
    #1;
    while (!reg_ready) begin @(negedge clk); #1; end
    @(negedge clk);
    reg_wr = 0;
  endtask

  task automatic rd(input logic [2:0] o, output logic [7:0] v);
    @(negedge clk);
    reg_rd = 1; reg_off = o;
    #1;
    while (!reg_ready) begin @(negedge clk); #1; end
    v = reg_rdata;
    @(negedge clk);
    reg_rd = 0;
  endtask

  task automatic rchk(input string req, input logic [2:0] o, input logic [7:0] exp);
    logic [7:0] v;
    rd(o, v);
    check(req, {8'b0, v}, {8'b0, exp});
  endtask

  task automatic settle();
    repeat (2) @(negedge clk);
    while (pend || op_valid) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 50000);
    n_chk++; n_bad++;
    $display("FAIL watchdog: got=running exp=finished");
    finish_run();
  end

  initial begin
    int n0;
    logic [7:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1;

    // reset state
    for (int i = 0; i < 5; i++) rchk("R10 reset value", 3'(i), 8'h00);
    check("R1 irq after reset", {15'b0, irq}, 16'h0);
    check("R11 idle after reset", {15'b0, op_valid}, 16'h0);

    // masks and unmapped offsets
    wr(3'd0, 8'hFF); rchk("R10 own mask", 3'd0, 8'hFE);
    wr(3'd1, 8'hFF); rchk("R10 divider mask", 3'd1, 8'h3F);
    wr(3'd5, 8'hAA); wr(3'd7, 8'h55);
    rchk("R10 unmapped read 5", 3'd5, 8'h00);
    rchk("R10 unmapped read 7", 3'd7, 8'h00);
    rchk("R10 own unchanged", 3'd0, 8'hFE);

    // disabled: data writes ignored
    n0 = op_seen;
    wr(3'd4, 8'hA4); settle();
    check("R5 disabled write no op", 16'(op_seen), 16'(n0));
    wr(3'd2, 8'h70);
    rchk("R3 busy set by master bit", 3'd3, 8'h20);
    wr(3'd4, 8'hA4); settle();
    check("R5 disabled master no op", 16'(op_seen), 16'(n0));
    wr(3'd2, 8'hF0);
    rchk("R10 control readback", 3'd2, 8'hF0);

    // start acked
    expect_op(2'd0, 8'hA4, 0);
    wr(3'd4, 8'hA4); settle();
    rchk("R6 start ack status", 3'd3, 8'h22);
    check("R1 irq raised", {15'b0, irq}, 16'h1);

    // write-zero clearing
    wr(3'd3, 8'hFF); rchk("R9 write one no effect", 3'd3, 8'h22);
    wr(3'd3, 8'hFD); rchk("R9 write zero clears", 3'd3, 8'h20);
    check("R9 irq lowered", {15'b0, irq}, 16'h0);

    // send ack, send nack
    expect_op(2'd1, 8'h3C, 0);
    wr(3'd4, 8'h3C); settle();
    rchk("R7 send ack status", 3'd3, 8'h22);
    wr(3'd3, 8'hFD);
    expect_op(2'd1, 8'h55, 1); expect_op(2'd3, 8'h00, 0);
    wr(3'd4, 8'h55); settle();
    rchk("R7 send nack status", 3'd3, 8'h21);
    check("R7 no irq on nack", {15'b0, irq}, 16'h0);

    // start nack then start again
    expect_op(2'd0, 8'h90, 1);
    wr(3'd4, 8'h90); settle();
    rchk("R6 start nack status", 3'd3, 8'h21);
    check("R6 no irq on nack", {15'b0, irq}, 16'h0);
    expect_op(2'd0, 8'h90, 0);
    wr(3'd4, 8'h90); settle();
    rchk("R6 retry start ack", 3'd3, 8'h22);
    wr(3'd3, 8'hFD);

    // repeated start
    expect_op(2'd3, 8'h00, 0);
    wr(3'd2, 8'hF4); settle();
    rchk("R4 restart bit cleared", 3'd2, 8'hF0);
    n0 = op_seen;
    wr(3'd2, 8'hF4); settle();
    rchk("R4 restart kept when idle", 3'd2, 8'hF4);
    check("R4 no op when idle", 16'(op_seen), 16'(n0));
    wr(3'd2, 8'hF0);

    // receive path
    expect_op(2'd0, 8'hA5, 0);
    wr(3'd4, 8'hA5); settle(); wr(3'd3, 8'hFD);
    wr(3'd2, 8'hE0);
    expect_op(2'd2, 8'h00, 0);
    rchk("R8 first read returns held", 3'd4, 8'h00); settle();
    rchk("R8 receive raises irq", 3'd3, 8'h22);
    wr(3'd3, 8'hFD);
    expect_op(2'd2, 8'h00, 0);
    rchk("R8 read returns received", 3'd4, 8'h5A); settle();
    wr(3'd3, 8'hFD);
    wr(3'd2, 8'hF0);
    n0 = op_seen;
    rchk("R8 read in transmit mode", 3'd4, 8'h5B); settle();
    rchk("R8 held byte forced FF", 3'd4, 8'hFF); settle();
    check("R8 no receive in transmit mode", 16'(op_seen), 16'(n0));
    rchk("R8 no irq in transmit mode", 3'd3, 8'h20);

    // stall and same-cycle set/clear
    expect_op(2'd1, 8'h66, 0);
    wr(3'd4, 8'h66); settle();
    auto_done = 0;
    expect_op(2'd1, 8'h11, 0);
    wr(3'd4, 8'h11);
    repeat (2) @(negedge clk);
    reg_rd = 1; reg_off = 3'd4; #1;
    check("R12 data stalled", {15'b0, reg_ready}, 16'h0);
    reg_off = 3'd2; #1;
    check("R12 control stalled", {15'b0, reg_ready}, 16'h0);
    reg_off = 3'd3; #1;
    check("R12 status not stalled", {15'b0, reg_ready}, 16'h1);
    reg_rd = 0;
    @(posedge clk); #1;
    reg_wr = 1; reg_off = 3'd3; reg_wdata = 8'hFD; man_fire = 1;
    @(posedge clk); #1;
    reg_wr = 0; auto_done = 1;
    settle();
    rchk("R13 set wins over clear", 3'd3, 8'h22);
    check("R13 irq stays high", {15'b0, irq}, 16'h1);
    wr(3'd3, 8'hFD);
    rchk("R9 later clear works", 3'd3, 8'h20);

    // leaving master mode ends the transfer
    expect_op(2'd3, 8'h00, 0);
    wr(3'd2, 8'hC0); settle();
    rchk("R3 busy cleared", 3'd3, 8'h00);

    // soft reset
    wr(3'd0, 8'h40); wr(3'd1, 8'h05); wr(3'd2, 8'hF0);
    expect_op(2'd0, 8'h20, 0);
    wr(3'd4, 8'h20); settle();
    expect_op(2'd3, 8'h00, 0);
    wr(3'd2, 8'h00); settle();
    rchk("R2 own address kept", 3'd0, 8'h40);
    rchk("R2 divider reset", 3'd1, 8'h00);
    rchk("R2 control reset", 3'd2, 8'h00);
    rchk("R2 status reset", 3'd3, 8'h00);
    rchk("R2 held byte reset", 3'd4, 8'h00);
    check("R2 irq low", {15'b0, irq}, 16'h0);

    // interrupt enable off
    wr(3'd2, 8'hB0);
    expect_op(2'd0, 8'h30, 0);
    wr(3'd4, 8'h30); settle();
    rchk("R1 no flag without enable", 3'd3, 8'h20);
    check("R1 irq low without enable", {15'b0, irq}, 16'h0);

    check("R11 all ops seen", 16'(exp_q.size()), 16'h0);
    finish_run();
  end
endmodule